// File: doc/BRIEF.md
# Cartridge PRG/Nametable Bank Mapper

This block sits on the cartridge side of an 8-bit console and turns the CPU bus into bank numbers for a program ROM, a page select for an on-cart work RAM, and chip enables for both. It also drives the page line of the console's nametable RAM from four one-bit registers, one for each nametable quadrant of the picture bus. Software programs it by writing a register index and then a value into the $8000-$9FFF area. The index goes in at an even address and the value at an odd one.

The CPU space from $6000 up is cut into sixteen 4 KiB windows chosen by A15..A12. Two windows are RAM holes ($6000 and $B000). One ROM window sits below $8000 at $7000. Fixed banks are interleaved with two switchable pairs whose upper four bank bits come from registers. The ROM enable is also driven in the $7000 window during writes, so the block raises a bus-conflict flag there. The bank lines never look at /ROMSEL. Registers load on the rising edge of their own write strobe, which is the end of the CPU write. An external reset clears all of them.

Top module: `cart_mapper`

## Requirements
- R1: A CPU write with /ROMSEL low, M2 high, R/W low, A14=A13=0 and A0=0 loads D2..D0 into the 3-bit register index. The value is taken when the strobe ends, which is the falling edge of M2.
- R2: The same kind of write with A0=1 stores data into the indexed register. Slots 2..5 keep D0 and slots 6 and 7 keep D3..D0. A write to slot 0 or 1 changes no output.
- R3: The 5-bit bank for a window given by A15..A12 is as follows. 8 gives {S6,0} and 9 gives {S6,1}. A gives 01100. C gives {S7,0} and D gives {S7,1}. E gives 01110 and F gives 01111. Here S6 and S7 are the 4-bit values of slots 6 and 7. RAM windows give 00000.
- R4: The bank lines never depend on /ROMSEL. Windows 0..5 give the same bank as windows 8..D. Window 6 gives 00000 and window 7 gives 11111.
- R5: ram_ce_n is low only while M2 is high and A15..A12 is 0110 or 1011. ram_page is 1 when A14..A12 = 011 and 0 otherwise.
- R6: rom_ce_n is low in two cases: on a read with /ROMSEL low outside window B, and while M2 is high in window 7, whether the access is a read or a write. A write in any other window leaves it high.
- R7: bus_conflict is high exactly when M2 is high, R/W is low and A15..A12 = 0111.
- R8: While PPU A13 is high, ciram_a10 equals a quadrant register. Quadrant {A11,A10}=00 uses slot 2, 10 uses slot 3, 01 uses slot 4 and 11 uses slot 5. While A13 is low, ciram_a10 is 0.
- R9: While ext_rst is high and after it falls, the index and all slots read zero. The switchable banks then read {0000,x} and ciram_a10 is 0.
- R10: A cycle that misses the strobe conditions changes no register. This covers R/W high, M2 staying low, and A14 or A13 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ext_rst | input | 1 | Asynchronous reset, active high |
| m2 | input | 1 | CPU phase-2 clock |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_romsel_n | input | 1 | Console ROM select, active low |
| cpu_addr_hi | input | 4 | CPU A15..A12 |
| cpu_a0 | input | 1 | CPU A0 |
| cpu_data | input | 4 | CPU D3..D0 |
| ppu_a13 | input | 1 | Picture bus A13 |
| ppu_a11 | input | 1 | Picture bus A11 |
| ppu_a10 | input | 1 | Picture bus A10 |
| prg_bank | output | 5 | 4 KiB ROM bank number |
| ram_page | output | 1 | Work RAM page |
| ram_ce_n | output | 1 | Work RAM enable, active low |
| rom_ce_n | output | 1 | Program ROM enable, active low |
| bus_conflict | output | 1 | Write into the ROM-enabled $7000 window |
| ciram_a10 | output | 1 | Nametable RAM page line |

## Verification
All 256 pairs of switchable values are written through the index and data ports. After each pair, a read sweep of the sixteen windows shows whether each window takes its bank from the right register, from a fixed value or from neither. A write sweep over the same windows separates the $7000 conflict window from every other window where ROM must stay off. It also toggles /ROMSEL under a fixed address to show that it has no effect on the bank. Random quadrant values checked against all eight picture-bus codes reveal a swapped quadrant order. Writes to slots 0 and 1, non-strobe cycles and resets during a run show whether any register changes when it should not.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int CM_BANK_W = 5;
  localparam int CM_SEL_W  = 4;
  localparam int CM_IDX_W  = 3;
  localparam int CM_NT_N   = 4;
  localparam int CM_WIN_W  = 4;

  // 5-bit bank for window code A15..A12; sel_a/sel_b are the switchable tops
  function automatic logic [CM_BANK_W-1:0] cm_bank_of(
      input logic [CM_WIN_W-1:0] win,
      input logic [CM_SEL_W-1:0] sel_a,
      input logic [CM_SEL_W-1:0] sel_b);
    logic [CM_BANK_W-1:0] b;
    unique case (win[2:0])
      3'd0: b = {sel_a, 1'b0};
      3'd1: b = {sel_a, 1'b1};
      3'd2: b = 5'b01100;
      3'd3: b = 5'b00000;
      3'd4: b = {sel_b, 1'b0};
      3'd5: b = {sel_b, 1'b1};
      3'd6: b = win[3] ? 5'b01110 : 5'b00000;
      default: b = win[3] ? 5'b01111 : 5'b11111;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/cm_regs.sv
module cm_regs
  import cm_pkg::*;
#(
  parameter int IDX_W = CM_IDX_W,
  parameter int SEL_W = CM_SEL_W,
  parameter int NT_N  = CM_NT_N
) (
  input  logic             ext_rst,
  input  logic             m2,
  input  logic             cpu_rw,
  input  logic             cpu_romsel_n,
  input  logic [1:0]       cpu_a14_13,
  input  logic             cpu_a0,
  input  logic [SEL_W-1:0] cpu_data,
  output logic             idx_stb_n,
  output logic             dat_stb_n,
  output logic [NT_N-1:0]  nt_bits,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b
);
  localparam int NT_BASE  = 2;
  localparam int SEL_BASE = NT_BASE + NT_N;
  localparam int SEL_N    = 2;

  logic             wr_cycle;
  logic [IDX_W-1:0] idx_q;
  logic [SEL_W-1:0] sel_q [SEL_N];

  assign wr_cycle  = !cpu_romsel_n && m2 && !cpu_rw && (cpu_a14_13 == 2'b00);
  assign idx_stb_n = !(wr_cycle && !cpu_a0);
  assign dat_stb_n = !(wr_cycle &&  cpu_a0);

  always_ff @(posedge idx_stb_n or posedge ext_rst) begin
    if (ext_rst) idx_q <= '0;
    else         idx_q <= cpu_data[IDX_W-1:0];
  end

  for (genvar i = 0; i < NT_N; i++) begin : g_nt
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(NT_BASE + i);
    always_ff @(posedge dat_stb_n or posedge ext_rst) begin
      if (ext_rst)            nt_bits[i] <= 1'b0;
      else if (idx_q == SLOT) nt_bits[i] <= cpu_data[0];
    end
  end

  for (genvar j = 0; j < SEL_N; j++) begin : g_sel
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(SEL_BASE + j);
    always_ff @(posedge dat_stb_n or posedge ext_rst) begin
      if (ext_rst)            sel_q[j] <= '0;
      else if (idx_q == SLOT) sel_q[j] <= cpu_data;
    end
  end

  assign sel_a = sel_q[0];
  assign sel_b = sel_q[1];
endmodule

// File: rtl/cm_prg_map.sv
module cm_prg_map
  import cm_pkg::*;
#(
  parameter int WIN_W  = CM_WIN_W,
  parameter int SEL_W  = CM_SEL_W,
  parameter int BANK_W = CM_BANK_W
) (
  input  logic              m2,
  input  logic              cpu_rw,
  input  logic              cpu_romsel_n,
  input  logic [WIN_W-1:0]  win,
  input  logic [SEL_W-1:0]  sel_a,
  input  logic [SEL_W-1:0]  sel_b,
  output logic [BANK_W-1:0] prg_bank,
  output logic              ram_page,
  output logic              ram_ce_n,
  output logic              rom_ce_n,
  output logic              bus_conflict
);
  localparam logic [WIN_W-1:0] WIN_RAM0 = WIN_W'(6);
  localparam logic [WIN_W-1:0] WIN_RAM1 = WIN_W'(11);
  localparam logic [WIN_W-1:0] WIN_LROM = WIN_W'(7);

  logic in_ram_win;
  logic in_low_rom;
  logic hi_rom_read;

  assign in_ram_win  = (win == WIN_RAM0) || (win == WIN_RAM1);
  assign in_low_rom  = (win == WIN_LROM);
  assign hi_rom_read = !cpu_romsel_n && cpu_rw && (win != WIN_RAM1);

  assign prg_bank     = cm_bank_of(win, sel_a, sel_b);
  assign ram_page     = (win[2:0] == 3'b011);
  assign ram_ce_n     = !(m2 && in_ram_win);
  assign rom_ce_n     = !(hi_rom_read || (m2 && in_low_rom));
  assign bus_conflict = m2 && !cpu_rw && in_low_rom;
endmodule

// File: rtl/cm_nt_sel.sv
module cm_nt_sel #(
  parameter int NT_N = 4
) (
  input  logic [NT_N-1:0] nt_bits,
  input  logic            ppu_a13,
  input  logic            ppu_a11,
  input  logic            ppu_a10,
  output logic            ciram_a10
);
  // quadrant slot index is {A10,A11}: the bus bits enter swapped
  logic [1:0] slot;
  assign slot      = {ppu_a10, ppu_a11};
  assign ciram_a10 = ppu_a13 && nt_bits[slot];
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cm_pkg::*;
#(
  parameter int BANK_W = CM_BANK_W,
  parameter int SEL_W  = CM_SEL_W,
  parameter int IDX_W  = CM_IDX_W,
  parameter int NT_N   = CM_NT_N,
  parameter int WIN_W  = CM_WIN_W
) (
  input  logic              ext_rst,
  input  logic              m2,
  input  logic              cpu_rw,
  input  logic              cpu_romsel_n,
  input  logic [WIN_W-1:0]  cpu_addr_hi,
  input  logic              cpu_a0,
  input  logic [SEL_W-1:0]  cpu_data,
  input  logic              ppu_a13,
  input  logic              ppu_a11,
  input  logic              ppu_a10,
  output logic [BANK_W-1:0] prg_bank,
  output logic              ram_page,
  output logic              ram_ce_n,
  output logic              rom_ce_n,
  output logic              bus_conflict,
  output logic              ciram_a10
);
  logic             idx_stb_n;
  logic             dat_stb_n;
  logic [NT_N-1:0]  nt_bits;
  logic [SEL_W-1:0] sel_a;
  logic [SEL_W-1:0] sel_b;

  cm_regs #(.IDX_W(IDX_W), .SEL_W(SEL_W), .NT_N(NT_N)) u_regs (
    .ext_rst     (ext_rst),
    .m2          (m2),
    .cpu_rw      (cpu_rw),
    .cpu_romsel_n(cpu_romsel_n),
    .cpu_a14_13  (cpu_addr_hi[2:1]),
    .cpu_a0      (cpu_a0),
    .cpu_data    (cpu_data),
    .idx_stb_n   (idx_stb_n),
    .dat_stb_n   (dat_stb_n),
    .nt_bits     (nt_bits),
    .sel_a       (sel_a),
    .sel_b       (sel_b)
  );

  cm_prg_map #(.WIN_W(WIN_W), .SEL_W(SEL_W), .BANK_W(BANK_W)) u_map (
    .m2          (m2),
    .cpu_rw      (cpu_rw),
    .cpu_romsel_n(cpu_romsel_n),
    .win         (cpu_addr_hi),
    .sel_a       (sel_a),
    .sel_b       (sel_b),
    .prg_bank    (prg_bank),
    .ram_page    (ram_page),
    .ram_ce_n    (ram_ce_n),
    .rom_ce_n    (rom_ce_n),
    .bus_conflict(bus_conflict)
  );

  cm_nt_sel #(.NT_N(NT_N)) u_nt (
    .nt_bits  (nt_bits),
    .ppu_a13  (ppu_a13),
    .ppu_a11  (ppu_a11),
    .ppu_a10  (ppu_a10),
    .ciram_a10(ciram_a10)
  );
endmodule

// File: rtl/cart_mapper_checker.sv
module cart_mapper_checker (
  input logic       ext_rst,
  input logic       m2,
  input logic       cpu_rw,
  input logic [3:0] cpu_addr_hi,
  input logic       ppu_a13,
  input logic [4:0] prg_bank,
  input logic       ram_ce_n,
  input logic       rom_ce_n,
  input logic       bus_conflict,
  input logic       ciram_a10,
  input logic       idx_stb_n,
  input logic       dat_stb_n
);
  // R6: a write outside the $7000 window never enables ROM
  p_no_rom_on_write_r6: assert property (@(negedge m2) disable iff (ext_rst)
    (!cpu_rw && cpu_addr_hi != 4'h7) |-> rom_ce_n);

  // R7: a conflict always coincides with an enabled ROM during a write
  p_conflict_rom_r7: assert property (@(negedge m2) disable iff (ext_rst)
    bus_conflict |-> (!rom_ce_n && !cpu_rw));

  // R5: RAM is enabled only inside its two holes
  p_ram_holes_r5: assert property (@(negedge m2) disable iff (ext_rst)
    !ram_ce_n |-> (cpu_addr_hi == 4'h6 || cpu_addr_hi == 4'hB));

  // R3: fixed window at $A000
  p_fixed_a_r3: assert property (@(negedge m2) disable iff (ext_rst)
    (cpu_addr_hi == 4'hA) |-> (prg_bank == 5'b01100));

  // R4: the window below $8000 holds the all-ones bank
  p_low_rom_r4: assert property (@(negedge m2) disable iff (ext_rst)
    (cpu_addr_hi == 4'h7) |-> (prg_bank == 5'b11111));

  // R8: picture bus A13 low forces page 0
  p_nt_a13_r8: assert property (@(negedge m2) disable iff (ext_rst)
    !ppu_a13 |-> !ciram_a10);

  // R1: the two strobes never fall together
  p_strobe_excl_r1: assert property (@(negedge m2) disable iff (ext_rst)
    $countones({!idx_stb_n, !dat_stb_n}) <= 1);

  // R9: under reset nothing selects page 1 and the switchable top is zero
  always @(negedge m2) begin
    if (ext_rst) begin
      p_reset_clear_r9: assert (!ciram_a10 &&
        (cpu_addr_hi != 4'h8 || prg_bank == 5'b00000));
    end
  end
endmodule

bind cart_mapper cart_mapper_checker u_chk (
  .ext_rst     (ext_rst),
  .m2          (m2),
  .cpu_rw      (cpu_rw),
  .cpu_addr_hi (cpu_addr_hi),
  .ppu_a13     (ppu_a13),
  .prg_bank    (prg_bank),
  .ram_ce_n    (ram_ce_n),
  .rom_ce_n    (rom_ce_n),
  .bus_conflict(bus_conflict),
  .ciram_a10   (ciram_a10),
  .idx_stb_n   (idx_stb_n),
  .dat_stb_n   (dat_stb_n)
);

// File: tb/cart_mapper_bench.sv
module cart_mapper_bench;
  localparam int CLK_PERIOD = 20;
  localparam int Q = CLK_PERIOD / 4;

  logic       ext_rst = 1'b1;
  logic       m2 = 1'b0;
  logic       cpu_rw = 1'b1;
  logic       cpu_romsel_n = 1'b1;
  logic [3:0] cpu_addr_hi = 4'h0;
  logic       cpu_a0 = 1'b0;
  logic [3:0] cpu_data = 4'h0;
  logic       ppu_a13 = 1'b0;
  logic       ppu_a11 = 1'b0;
  logic       ppu_a10 = 1'b0;
  logic [4:0] prg_bank;
  logic       ram_page, ram_ce_n, rom_ce_n, bus_conflict, ciram_a10;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [3:0] m_a, m_b;
  logic [3:0] m_nt;   // bit k = slot 2+k

  cart_mapper u_cart_mapper (
    .ext_rst(ext_rst), .m2(m2), .cpu_rw(cpu_rw), .cpu_romsel_n(cpu_romsel_n),
    .cpu_addr_hi(cpu_addr_hi), .cpu_a0(cpu_a0), .cpu_data(cpu_data),
    .ppu_a13(ppu_a13), .ppu_a11(ppu_a11), .ppu_a10(ppu_a10),
    .prg_bank(prg_bank), .ram_page(ram_page), .ram_ce_n(ram_ce_n),
    .rom_ce_n(rom_ce_n), .bus_conflict(bus_conflict), .ciram_a10(ciram_a10));

  function automatic logic [4:0] ref_bank(int w, logic [3:0] a, logic [3:0] b);
    case (w)
      0, 8:   return {a, 1'b0};
      1, 9:   return {a, 1'b1};
      2, 10:  return 5'd12;
      4, 12:  return {b, 1'b0};
      5, 13:  return {b, 1'b1};
      7:      return 5'd31;
      14:     return 5'd14;
      15:     return 5'd15;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic ref_nt(logic [3:0] nt, logic a13, logic a11, logic a10);
    if (!a13) return 1'b0;
    if (!a11 && !a10) return nt[0];
    if ( a11 && !a10) return nt[1];
    if (!a11 &&  a10) return nt[2];
    return nt[3];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic bus_begin(input logic [3:0] hi, input logic a0, input logic rw,
                           input logic [3:0] d, input logic romsel_n);
    cpu_addr_hi = hi; cpu_a0 = a0; cpu_rw = rw; cpu_data = d;
    #(Q);
    m2 = 1'b1; cpu_romsel_n = romsel_n;
    #(Q);
  endtask

  task automatic bus_end();
    #(Q);
    m2 = 1'b0; cpu_romsel_n = 1'b1;
    #(Q);
    cpu_rw = 1'b1;
  endtask

  task automatic wr(input logic [3:0] hi, input logic a0, input logic [3:0] d);
    bus_begin(hi, a0, 1'b0, d, ~hi[3]);
    bus_end();
  endtask

  task automatic set_slot(input logic [2:0] idx, input logic [3:0] v);
    wr(4'h8, 1'b0, {1'b0, idx});
    wr(4'h9, 1'b1, v);
  endtask

  task automatic read_win(input string req, input int w);
    bus_begin(4'(w), 1'b0, 1'b1, 4'h0, ~w[3]);
    chk(req, "bank", 32'(prg_bank), 32'(ref_bank(w, m_a, m_b)));
    chk(req, "ram_page", 32'(ram_page), 32'(w[2:0] == 3'b011));
    chk("R5", "ram_ce_n", 32'(ram_ce_n), 32'(!(w == 6 || w == 11)));
    chk("R6", "rom_ce_n rd", 32'(rom_ce_n), 32'(!((w >= 8 && w != 11) || w == 7)));
    chk("R7", "conflict rd", 32'(bus_conflict), 32'(0));
    bus_end();
  endtask

  task automatic check_nt(input string req);
    for (int k = 0; k < 8; k++) begin
      ppu_a13 = k[2]; ppu_a11 = k[1]; ppu_a10 = k[0];
      #1;
      chk(req, "ciram_a10", 32'(ciram_a10), 32'(ref_nt(m_nt, k[2], k[1], k[0])));
    end
  endtask

  task automatic sweep_all(input string req);
    for (int w = 0; w < 16; w++) read_win(req, w);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_a = 0; m_b = 0; m_nt = 0;

    // R9: reset state, probed while reset is held
    #(CLK_PERIOD);
    bus_begin(4'h8, 1'b0, 1'b1, 4'h0, 1'b0);
    chk("R9", "bank in reset", 32'(prg_bank), 32'(0));
    bus_end();
    check_nt("R9");
    ext_rst = 1'b0;
    #(CLK_PERIOD);
    sweep_all("R9");

    // R1 R2 R3 R5 R6: every pair of switchable values, full read sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_slot(3'd6, 4'(a));
        set_slot(3'd7, 4'(b));
        m_a = 4'(a); m_b = 4'(b);
        sweep_all("R3");
      end
    end

    // R6 R7 R5: write sweep; index data kept at slot 6 so nothing changes
    for (int w = 0; w < 16; w++) begin
      bus_begin(4'(w), 1'b0, 1'b0, 4'h6, ~w[3]);
      chk("R6", "rom_ce_n wr", 32'(rom_ce_n), 32'(w != 7));
      chk("R7", "conflict wr", 32'(bus_conflict), 32'(w == 7));
      chk("R5", "ram_ce_n wr", 32'(ram_ce_n), 32'(!(w == 6 || w == 11)));
      bus_end();
    end

    // R4: /ROMSEL has no effect on the bank lines
    for (int w = 0; w < 16; w++) begin
      bus_begin(4'(w), 1'b0, 1'b1, 4'h0, 1'b0);
      chk("R4", "bank romsel lo", 32'(prg_bank), 32'(ref_bank(w, m_a, m_b)));
      cpu_romsel_n = 1'b1; #1;
      chk("R4", "bank romsel hi", 32'(prg_bank), 32'(ref_bank(w, m_a, m_b)));
      bus_end();
    end

    // R8: random quadrant contents
    for (int it = 0; it < 24; it++) begin
      logic [3:0] v;
      v = 4'($urandom);
      for (int s = 0; s < 4; s++) set_slot(3'(2 + s), {3'($urandom), v[s]});
      m_nt = v;
      check_nt("R8");
    end
    m_nt = 4'b0110;
    for (int s = 0; s < 4; s++) set_slot(3'(2 + s), {3'b000, m_nt[s]});
    check_nt("R8");

    // R2: writes into slots 0 and 1 are dropped
    set_slot(3'd0, 4'hF);
    set_slot(3'd1, 4'hA);
    sweep_all("R2");
    check_nt("R2");

    // R10: non-strobe cycles leave every register alone
    wr(4'h8, 1'b0, 4'h6);
    bus_begin(4'h9, 1'b1, 1'b1, 4'h3, 1'b0); bus_end();   // read
    wr(4'hA, 1'b1, 4'h3);                               // A13 set
    wr(4'hC, 1'b1, 4'h3);                               // A14 set
    cpu_addr_hi = 4'h9; cpu_a0 = 1'b1; cpu_rw = 1'b0; cpu_data = 4'h3;
    #(CLK_PERIOD); cpu_rw = 1'b1;                        // M2 never rises
    sweep_all("R10");
    check_nt("R10");

    // R9: reset in mid-run clears slots and index
    ext_rst = 1'b1; #(Q); ext_rst = 1'b0; #(Q);
    m_a = 0; m_b = 0; m_nt = 0;
    wr(4'h9, 1'b1, 4'hF);   // index is 0, so this is dropped
    sweep_all("R9");
    check_nt("R9");

    // R1: index latched from an even address, value from an odd one
    wr(4'h8, 1'b0, 4'h7);
    wr(4'h9, 1'b1, 4'h9);
    m_b = 4'h9;
    read_win("R1", 12);
    read_win("R1", 13);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule